// File: doc/BRIEF.md
# Phase build-out switching controller

This block sits beside a digital PLL and keeps the output clock from showing a phase step when the active input reference changes. It watches a set of prioritized references, each with three independent fault flags. When the reference in use goes bad, the block moves to the best remaining reference. It then holds the loop in a short holdover and times the new reference's edge against the output edge, counting system-clock cycles. The signed result is added to a running phase offset that the loop consumes, so the loop sees no phase jump after the switch.

Software sets one of three modes. In the enabled mode every switch runs the holdover and measurement. In the frozen mode the current offset is kept and later switches skip the measurement. In the disabled mode the offset is zero and switches go straight to tracking. Reference 0 has the highest priority. Selection is non-revertive: a reference that recovers does not take over from one that is still good.

Top module: `pbo_switch_ctrl`

## Requirements
- R1: A reference is invalid while any of its short-interruption, out-of-range or lost flags is 1. When the selected reference becomes invalid while another reference is valid, `sel_o` changes to a different, valid reference one clock later.
- R2: On a failover, `sel_o` takes the lowest-numbered valid reference, and `evt_o` goes to 1 and stays there until `evt_clr` is pulsed with no new failover. A reference that recovers does not take over from a selected reference that is still valid.
- R3: In the enabled mode a failover raises `holdover_o`. The flag stays high and `offset_o` stays unchanged until the measurement completes.
- R4: The measurement starts at the first selected-reference edge or output edge seen during holdover and ends at the other one. It yields +d when the reference edge leads the output edge by d cycles, −d when the output edge leads by d cycles, and 0 when both edges fall in the same cycle. `holdover_o` falls in the cycle the result is taken.
- R5: A measurement whose second edge has not come HALF_PER cycles after the first edge ends at that point with ±HALF_PER.
- R6: `offset_o` is a signed 16-bit running sum of the measurement results, saturating at the 16-bit limits.
- R7: After reset, `mode_o` is 00 (enabled), `offset_o` is 0 and `evt_o` is 0. The block then selects the lowest-numbered valid reference, with no event and no holdover.
- R8: Writing 10 selects the frozen mode. `offset_o` is then held, and a failover changes `sel_o` without holdover or any offset change.
- R9: Writing 01 selects the disabled mode. `offset_o` becomes 0 and a failover goes straight to tracking without holdover.
- R10: A mode write of 11 is ignored and `mode_o` keeps its value.
- R11: While no reference is valid, `all_lost_o` and `holdover_o` are 1. When a reference becomes valid again, it is selected, `evt_o` is set and `all_lost_o` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_edge | input | NREF | One-cycle strobe per reference clock edge |
| ref_short_loss | input | NREF | Short-interruption fault per reference |
| ref_freq_bad | input | NREF | Out-of-frequency-range fault per reference |
| ref_lost | input | NREF | Complete-loss fault per reference |
| out_edge | input | 1 | One-cycle strobe on each output clock edge |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode value: 00 enabled, 01 disabled, 10 frozen |
| evt_clr | input | 1 | Clears the sticky event flag |
| mode_o | output | 2 | Current mode |
| offset_o | output | 16 | Signed accumulated phase offset to the loop |
| sel_o | output | SEL_W | Index of the selected reference |
| holdover_o | output | 1 | Loop must hold frequency and ignore inputs |
| evt_o | output | 1 | Sticky build-out event flag |
| all_lost_o | output | 1 | No reference is valid |

## Verification
The bench measures with the reference edge first and with the output edge first, so a design that ignores the sign would drift the offset in the wrong direction. It also sends both edges in the same cycle, where a design that counts one stray cycle would add a spurious unit. It holds back the second edge to check that saturation ends the measurement, where a design without saturation would stay in holdover. It revives a higher-priority reference during tracking and then fails over with two candidates valid, which catches revertive switching and a wrong priority order. It changes mode in the middle of operation to check that frozen mode holds the offset, that disabled mode clears it, and that a write of 11 leaves the mode unchanged.

// File: rtl/pbo_pkg.sv
package pbo_pkg;
  localparam int OFS_W = 16;

  typedef enum logic [1:0] {
    PBO_ON  = 2'b00,
    PBO_OFF = 2'b01,
    PBO_FRZ = 2'b10
  } pbo_mode_e;

  typedef enum logic [1:0] {
    ST_SEARCH,
    ST_TRACK,
    ST_MEAS,
    ST_LOST
  } pbo_st_e;

  // saturating signed add on the offset width
  function automatic logic signed [OFS_W-1:0] sat_add(
    input logic signed [OFS_W-1:0] a,
    input logic signed [OFS_W-1:0] b
  );
    logic signed [OFS_W:0] s;
    s = {a[OFS_W-1], a} + {b[OFS_W-1], b};
    if (s[OFS_W] != s[OFS_W-1])
      sat_add = s[OFS_W] ? {1'b1, {(OFS_W-1){1'b0}}} : {1'b0, {(OFS_W-1){1'b1}}};
    else
      sat_add = s[OFS_W-1:0];
  endfunction
endpackage

// File: rtl/pbo_prio_pick.sv
module pbo_prio_pick #(
  parameter int NREF  = 4,
  parameter int SEL_W = 2
) (
  input  logic [NREF-1:0]  valid,
  output logic             any_valid,
  output logic [SEL_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = NREF - 1; i >= 0; i--)
      if (valid[i]) idx = SEL_W'(i);
  end
  assign any_valid = |valid;
endmodule

// File: rtl/pbo_phase_meter.sv
module pbo_phase_meter #(
  parameter int HALF_PER = 8,
  parameter int CNT_W    = 4,
  parameter int PH_W     = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   clr,
  input  logic                   in_edge,
  input  logic                   out_edge,
  output logic                   done,
  output logic signed [PH_W-1:0] phase
);
  typedef enum logic [1:0] {M_WAIT, M_IN, M_OUT} m_st_e;
  m_st_e            st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_lim;

  assign at_lim = (cnt_q == CNT_W'(HALF_PER));

  always_comb begin
    done  = 1'b0;
    phase = '0;
    if (run && !clr) begin
      case (st_q)
        M_WAIT: done = in_edge && out_edge;
        M_IN: begin
          done  = out_edge || at_lim;
          phase = $signed({1'b0, cnt_q});
        end
        M_OUT: begin
          done  = in_edge || at_lim;
          phase = -$signed({1'b0, cnt_q});
        end
        default: done = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run || clr || done) begin
      st_q  <= M_WAIT;
      cnt_q <= '0;
    end else begin
      case (st_q)
        M_WAIT: begin
          if (in_edge) begin
            st_q  <= M_IN;
            cnt_q <= CNT_W'(1);
          end else if (out_edge) begin
            st_q  <= M_OUT;
            cnt_q <= CNT_W'(1);
          end
        end
        default: cnt_q <= cnt_q + 1'b1;
      endcase
    end
  end

  // R5
  ph_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phase <= $signed(PH_W'(HALF_PER)) && phase >= -$signed(PH_W'(HALF_PER))));
  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != M_WAIT) |-> (cnt_q <= CNT_W'(HALF_PER)));
endmodule

// File: rtl/pbo_offset_acc.sv
module pbo_offset_acc
  import pbo_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  pbo_mode_e               mode,
  input  logic                    add_en,
  input  logic signed [OFS_W-1:0] delta,
  output logic signed [OFS_W-1:0] offset
);
  always_ff @(posedge clk) begin
    if (!rst_n || mode == PBO_OFF) offset <= '0;
    else if (add_en && mode == PBO_ON) offset <= sat_add(offset, delta);
  end

  // R8
  frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PBO_FRZ) |=> $stable(offset));
  // R9
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PBO_OFF) |=> (offset == '0));
endmodule

// File: rtl/pbo_switch_ctrl.sv
module pbo_switch_ctrl
  import pbo_pkg::*;
#(
  parameter int NREF     = 4,
  parameter int HALF_PER = 8,
  localparam int SEL_W   = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NREF-1:0]         ref_edge,
  input  logic [NREF-1:0]         ref_short_loss,
  input  logic [NREF-1:0]         ref_freq_bad,
  input  logic [NREF-1:0]         ref_lost,
  input  logic                    out_edge,
  input  logic                    mode_wr,
  input  logic [1:0]              mode_wdata,
  input  logic                    evt_clr,
  output logic [1:0]              mode_o,
  output logic signed [OFS_W-1:0] offset_o,
  output logic [SEL_W-1:0]        sel_o,
  output logic                    holdover_o,
  output logic                    evt_o,
  output logic                    all_lost_o
);
  localparam int CNT_W = $clog2(HALF_PER + 1);
  localparam int PH_W  = CNT_W + 1;

  logic [NREF-1:0] valid;
  for (genvar i = 0; i < NREF; i++) begin : g_valid
    assign valid[i] = ~(ref_short_loss[i] | ref_freq_bad[i] | ref_lost[i]);
  end

  pbo_mode_e        mode_q;
  pbo_st_e          st_q, st_d;
  logic [SEL_W-1:0] sel_q, sel_d, pick_idx;
  logic             any_valid, sel_ok, fail, swap, evt_q, lost_q;
  logic             meas_done;
  logic signed [PH_W-1:0]  meas_ph;
  logic signed [OFS_W-1:0] delta;

  pbo_prio_pick #(.NREF(NREF), .SEL_W(SEL_W)) u_pick (
    .valid(valid), .any_valid(any_valid), .idx(pick_idx)
  );

  assign sel_ok = valid[sel_q];
  assign fail   = (st_q == ST_TRACK || st_q == ST_MEAS) && !sel_ok;
  assign swap   = (fail || st_q == ST_LOST) && any_valid;

  always_comb begin
    st_d  = st_q;
    sel_d = sel_q;
    case (st_q)
      ST_SEARCH: if (any_valid) begin
        sel_d = pick_idx;
        st_d  = ST_TRACK;
      end
      ST_LOST: if (any_valid) begin
        sel_d = pick_idx;
        st_d  = (mode_q == PBO_ON) ? ST_MEAS : ST_TRACK;
      end
      default: begin
        if (!sel_ok) begin
          if (any_valid) begin
            sel_d = pick_idx;
            st_d  = (mode_q == PBO_ON) ? ST_MEAS : ST_TRACK;
          end else begin
            st_d = ST_LOST;
          end
        end else if (st_q == ST_MEAS && (mode_q != PBO_ON || meas_done)) begin
          st_d = ST_TRACK;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_SEARCH;
      sel_q  <= '0;
      mode_q <= PBO_ON;
      evt_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      lost_q <= !any_valid;
      if (mode_wr && mode_wdata != 2'b11) mode_q <= pbo_mode_e'(mode_wdata);
      if (swap) evt_q <= 1'b1;
      else if (evt_clr) evt_q <= 1'b0;
    end
  end

  pbo_phase_meter #(.HALF_PER(HALF_PER), .CNT_W(CNT_W), .PH_W(PH_W)) u_meter (
    .clk(clk), .rst_n(rst_n),
    .run(st_q == ST_MEAS && mode_q == PBO_ON), .clr(swap || fail),
    .in_edge(ref_edge[sel_q]), .out_edge(out_edge),
    .done(meas_done), .phase(meas_ph)
  );

  assign delta = {{(OFS_W-PH_W){meas_ph[PH_W-1]}}, meas_ph};

  pbo_offset_acc u_acc (
    .clk(clk), .rst_n(rst_n), .mode(mode_q),
    .add_en(meas_done), .delta(delta), .offset(offset_o)
  );

  assign mode_o     = mode_q;
  assign sel_o      = sel_q;
  assign holdover_o = (st_q != ST_TRACK);
  assign evt_o      = evt_q;
  assign all_lost_o = lost_q;

  // R1
  failover_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && any_valid) |=> (evt_o && sel_o != $past(sel_o)));
  // R3
  meas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MEAS && !meas_done && mode_q == PBO_ON) |=> $stable(offset_o));
  // R10
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_wdata == 2'b11) |=> $stable(mode_o));
  // R11
  lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_lost_o |-> holdover_o);
endmodule

// File: tb/pbo_switch_ctrl_bench.sv
module pbo_switch_ctrl_bench;
  localparam int NREF = 4;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREF-1:0] ref_edge = '0, ref_short_loss = '0, ref_freq_bad = '0, ref_lost = '0;
  logic out_edge = 1'b0, mode_wr = 1'b0, evt_clr = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic [1:0] mode_o;
  logic signed [15:0] offset_o;
  logic [1:0] sel_o;
  logic holdover_o, evt_o, all_lost_o;

  pbo_switch_ctrl #(.NREF(NREF), .HALF_PER(HALF)) u_pbo_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .ref_short_loss(ref_short_loss),
    .ref_freq_bad(ref_freq_bad), .ref_lost(ref_lost), .out_edge(out_edge),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .evt_clr(evt_clr),
    .mode_o(mode_o), .offset_o(offset_o), .sel_o(sel_o), .holdover_o(holdover_o),
    .evt_o(evt_o), .all_lost_o(all_lost_o)
  );

  always #2.5 clk = ~clk;

  typedef struct { string req; int fld; int val; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  int exp_ofs = 0;
  int exp_sel = 0;
  bit finished = 0;

  function automatic int field_val(int f);
    case (f)
      0: return int'(offset_o);
      1: return int'(sel_o);
      2: return int'(holdover_o);
      3: return int'(evt_o);
      4: return int'(all_lost_o);
      default: return int'(mode_o);
    endcase
  endfunction

  // monitor: compares queued expectations just after each rising edge
  always @(posedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (field_val(it.fld) != it.val) begin
        errors++;
        $display("FAIL %s field %0d: actual %0d expected %0d", it.req, it.fld, field_val(it.fld), it.val);
      end
    end
  end

  task automatic expect_f(string req, int fld, int val);
    item_t it;
    it.req = req; it.fld = fld; it.val = val;
    q.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int clamp16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // t_in / t_out: cycle of each edge after start, -1 = never sent
  task automatic run_meas(int t_in, int t_out, string req);
    int first, done_at, ph;
    if (t_in >= 0 && t_out >= 0) begin
      first = (t_in < t_out) ? t_in : t_out;
      ph = t_out - t_in;
      if (ph > HALF) ph = HALF;
      if (ph < -HALF) ph = -HALF;
      done_at = first + ((ph < 0) ? -ph : ph);
    end else if (t_in >= 0) begin
      done_at = t_in + HALF; ph = HALF;
    end else begin
      done_at = t_out + HALF; ph = -HALF;
    end
    for (int k = 0; k <= done_at; k++) begin
      ref_edge = '0;
      ref_edge[exp_sel] = (k == t_in);
      out_edge = (k == t_out);
      if (k == done_at) begin
        exp_ofs = clamp16(exp_ofs + ph);
        expect_f(req, 0, exp_ofs);
        expect_f(req, 2, 0);
      end else begin
        expect_f("R3", 2, 1);
      end
      tick();
    end
    ref_edge = '0;
    out_edge = 1'b0;
    tick();
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R7 reset values
    expect_f("R7", 0, 0); expect_f("R7", 5, 0); expect_f("R7", 3, 0); expect_f("R7", 4, 0);
    tick();
    rst_n = 1'b1;
    expect_f("R7", 1, 0); expect_f("R7", 2, 0); expect_f("R7", 3, 0);
    tick();

    // R1 lost flag on ref 0
    ref_lost[0] = 1'b1; exp_sel = 1;
    expect_f("R1", 1, 1); expect_f("R3", 2, 1); expect_f("R1", 3, 1);
    tick();
    run_meas(0, 2, "R4");            // +2
    // R1 short interruption on ref 1
    ref_short_loss[1] = 1'b1; exp_sel = 2;
    expect_f("R1", 1, 2); expect_f("R3", 2, 1);
    tick();
    run_meas(5, 0, "R4");            // -5
    // R1 frequency fault on ref 2, saturating measurement
    ref_freq_bad[2] = 1'b1; exp_sel = 3;
    expect_f("R1", 1, 3);
    tick();
    run_meas(0, -1, "R5");           // +HALF

    // R11 all references lost
    ref_lost[3] = 1'b1;
    expect_f("R11", 4, 1); expect_f("R11", 2, 1);
    tick(); tick();
    expect_f("R11", 4, 1); expect_f("R11", 2, 1);
    tick();
    evt_clr = 1'b1; tick(); evt_clr = 1'b0;
    ref_short_loss[1] = 1'b0; exp_sel = 1;
    expect_f("R11", 1, 1); expect_f("R11", 4, 0); expect_f("R11", 3, 1); expect_f("R11", 2, 1);
    tick();
    run_meas(0, 0, "R4");            // same cycle: 0

    // R2 non-revertive, sticky clear, priority
    ref_lost[0] = 1'b0;
    expect_f("R2", 1, 1); expect_f("R2", 2, 0);
    tick();
    evt_clr = 1'b1; expect_f("R2", 3, 0); tick(); evt_clr = 1'b0;
    ref_freq_bad[2] = 1'b0; tick();
    ref_short_loss[1] = 1'b1; exp_sel = 0;
    expect_f("R2", 1, 0); expect_f("R2", 3, 1);
    tick();
    run_meas(0, 1, "R6");            // accumulated 2-5+8+0+1 = 6

    // R8 frozen
    mode_wr = 1'b1; mode_wdata = 2'b10; expect_f("R8", 5, 2); tick(); mode_wr = 1'b0;
    ref_lost[0] = 1'b1; exp_sel = 2;
    expect_f("R8", 1, 2); expect_f("R8", 2, 0); expect_f("R8", 0, exp_ofs);
    tick();
    ref_edge[2] = 1'b1; tick(); ref_edge = '0; out_edge = 1'b1; tick(); out_edge = 1'b0;
    expect_f("R8", 0, exp_ofs); expect_f("R8", 2, 0);
    tick();

    // R10 reserved mode value
    mode_wr = 1'b1; mode_wdata = 2'b11; expect_f("R10", 5, 2); tick(); mode_wr = 1'b0;
    tick();

    // R9 disabled
    mode_wr = 1'b1; mode_wdata = 2'b01; expect_f("R9", 5, 1); tick(); mode_wr = 1'b0;
    exp_ofs = 0; expect_f("R9", 0, 0); tick();
    ref_lost[0] = 1'b0; tick();
    ref_freq_bad[2] = 1'b1; exp_sel = 0;
    expect_f("R9", 1, 0); expect_f("R9", 2, 0); expect_f("R9", 0, 0);
    tick();

    // R3 enabled again, offset held through holdover
    mode_wr = 1'b1; mode_wdata = 2'b00; expect_f("R7", 5, 0); tick(); mode_wr = 1'b0;
    ref_short_loss[1] = 1'b0; tick();
    ref_lost[0] = 1'b1; exp_sel = 1;
    expect_f("R3", 1, 1); expect_f("R3", 2, 1); expect_f("R3", 0, 0);
    tick();
    for (int k = 0; k < 3; k++) begin
      expect_f("R3", 2, 1); expect_f("R3", 0, 0);
      tick();
    end
    run_meas(0, 3, "R4");            // +3

    repeat (3) tick();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule